// File: doc/BRIEF.md
# BF16 Immediate to Double Expander

This block is the datapath of a floating-point load-immediate operation. It takes a 32-bit instruction word and checks its major opcode and extended opcode against configured values. On a match it rebuilds a 16-bit brain-float constant from two separate fields of the word. It then widens that constant exactly into a 64-bit IEEE-754 double, ready to be written to a floating-point register. The 5-bit destination register index travels with the result.

The 16-bit constant is read as the upper half of a single-precision pattern whose lower 16 bits are zero. Every such pattern has an exact double equivalent, so no rounding is ever needed. Zeros keep their sign. Normal numbers are rebiased. Single-precision subnormals become normal doubles. Infinities and NaNs keep their sign and payload bits.

Both sides of the block use valid/ready streams. An input word is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so a stalled consumer stops the input with no bubble and no loss. A result stays on the output, unchanged, until it is taken on an edge where `out_valid` and `out_ready` are both high.

Top module: `bf16_imm_expand`

## Requirements
- R1: Bit numbering is LSB0. The major opcode is `in_insn[31:26]` and the destination index is `in_insn[25:21]`. The low 15 bits of the immediate are `in_insn[20:6]`, the extended opcode is `in_insn[5:1]`, and the immediate's top bit is `in_insn[0]`. `out_rd` carries the destination index.
- R2: A word is processed only if its major opcode equals `MAJOR_OP` (default 19) and its extended opcode equals `EXT_OP` (default 3). Any other accepted word is consumed and produces no output.
- R3: An immediate with exponent bits `[14:7]` and mantissa bits `[6:0]` all zero gives a double zero with the immediate's sign: `0x0000` gives `0x0000000000000000` and `0x8000` gives `0x8000000000000000`.
- R4: For a normal immediate (exponent 1..254), the double exponent is the input exponent plus 896. The 7 mantissa bits become double fraction bits `[51:45]`, and fraction bits `[44:0]` are zero. Examples: `0x3F80` gives `0x3FF0000000000000`, `0xBFC0` gives `0xBFF8000000000000`, and `0x3FFF` gives `0x3FFFE00000000000`.
- R5: An immediate with exponent 255 gives double exponent `0x7FF` with the sign kept and the 7 payload bits in fraction bits `[51:45]`. Examples: `0x7F80` gives `0x7FF0000000000000`, `0xFF80` gives `0xFFF0000000000000`, and `0x7FC0` gives `0x7FF8000000000000`.
- R6: A subnormal immediate (exponent 0, mantissa nonzero) is normalised. With `lz` the count of leading zeros in the 7-bit mantissa, the double exponent is `896 - lz`. The fraction holds the mantissa bits below its leading one, left-aligned. Examples: `0x0001` gives `0x37A0000000000000` and `0x8005` gives `0xB7C4000000000000`.
- R7: A matching word accepted on a clock edge puts its result on the outputs with `out_valid` high right after that edge. With `out_ready` held high, `out_valid` stays high for exactly one cycle per accepted matching word.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` and `out_rd` hold their values.
- R9: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word is present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Expanded IEEE double |
| out_rd | output | 5 | Destination register index |

## Verification
A result is due one clock edge after the edge that accepts a matching word. A non-matching word must cause no output on that edge. The driver changes inputs 1 ns after the rising edge and records the expected double at the accepting edge. The monitor compares results at the falling edge, where out_valid and out_ready show the transfer that the next rising edge completes. Timing checks sample 1 ns after the relevant edge: out_valid must be high after the accepting edge and low one edge later. During a stall, in_ready and the held result are checked once per cycle.

// File: rtl/bf16x_pkg.sv
package bf16x_pkg;
  localparam int INSN_W     = 32;
  localparam int IMM_W      = 16;
  localparam int IN_EXP_W   = 8;
  localparam int IN_MAN_W   = 7;
  localparam int OUT_EXP_W  = 11;
  localparam int OUT_FRAC_W = 52;
  localparam int DBL_W      = 1 + OUT_EXP_W + OUT_FRAC_W;
  localparam int RD_W       = 5;
  localparam int OPC_W      = 6;
  localparam int XOP_W      = 5;
  localparam int IN_BIAS    = (1 << (IN_EXP_W - 1)) - 1;
  localparam int OUT_BIAS   = (1 << (OUT_EXP_W - 1)) - 1;
  localparam int BIAS_ADJ   = OUT_BIAS - IN_BIAS;

  localparam logic [OPC_W-1:0] DEF_MAJOR = 6'd19;
  localparam logic [XOP_W-1:0] DEF_EXT   = 5'd3;

  typedef struct packed {
    logic [DBL_W-1:0] dbl;
    logic [RD_W-1:0]  rd;
  } result_t;
endpackage

// File: rtl/bf16x_field_split.sv
module bf16x_field_split
  import bf16x_pkg::*;
#(
  parameter logic [OPC_W-1:0] MAJOR_OP = DEF_MAJOR,
  parameter logic [XOP_W-1:0] EXT_OP   = DEF_EXT
) (
  input  logic [INSN_W-1:0] insn,
  output logic [IMM_W-1:0]  imm,
  output logic [RD_W-1:0]   rd,
  output logic              hit
);
  localparam int OPC_LSB = INSN_W - OPC_W;
  localparam int RD_LSB  = OPC_LSB - RD_W;
  localparam int XOP_LSB = 1;
  localparam int IMLO_W  = IMM_W - 1;
  localparam int IMLO_LSB = XOP_LSB + XOP_W;

  logic [OPC_W-1:0] opc;
  logic [XOP_W-1:0] xop;

  always_comb begin
    opc = insn[INSN_W-1 -: OPC_W];
    xop = insn[XOP_LSB +: XOP_W];
    rd  = insn[RD_LSB +: RD_W];
    imm = {insn[0], insn[IMLO_LSB +: IMLO_W]};
    hit = (opc == MAJOR_OP) && (xop == EXT_OP);
  end
endmodule

// File: rtl/bf16x_lzc.sv
module bf16x_lzc #(
  parameter int W  = 7,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  logic [W:0] seen;
  logic [CW-1:0] part [W+1];

  assign seen[W] = 1'b0;
  assign part[W] = '0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_scan
    assign seen[i] = seen[i+1] | vec[i];
    assign part[i] = (seen[i+1] || vec[i]) ? part[i+1] : CW'(W - i);
  end

  assign cnt = part[0];
endmodule

// File: rtl/bf16x_widen.sv
module bf16x_widen
  import bf16x_pkg::*;
(
  input  logic [IMM_W-1:0] imm,
  output logic [DBL_W-1:0] dbl
);
  localparam int LZ_W  = $clog2(IN_MAN_W + 1);
  localparam int PAD_W = OUT_FRAC_W - IN_MAN_W;
  localparam logic [IN_EXP_W-1:0]  EXP_ONES  = '1;
  localparam logic [OUT_EXP_W-1:0] OEXP_ONES = '1;

  logic                 sgn;
  logic [IN_EXP_W-1:0]  exp_in;
  logic [IN_MAN_W-1:0]  man_in;
  logic [LZ_W-1:0]      lz;
  logic [IN_MAN_W:0]    shifted;
  logic [OUT_EXP_W-1:0] exp_out;
  logic [IN_MAN_W-1:0]  man_out;

  assign sgn    = imm[IMM_W-1];
  assign exp_in = imm[IN_MAN_W +: IN_EXP_W];
  assign man_in = imm[IN_MAN_W-1:0];

  bf16x_lzc #(.W(IN_MAN_W), .CW(LZ_W)) u_lzc (
    .vec (man_in),
    .cnt (lz)
  );

  always_comb begin
    shifted = {1'b0, man_in} << (int'(lz) + 1);
    if (exp_in == '0) begin
      if (man_in == '0) begin
        exp_out = '0;
        man_out = '0;
      end else begin
        exp_out = OUT_EXP_W'(BIAS_ADJ - int'(lz));
        man_out = shifted[IN_MAN_W-1:0];
      end
    end else if (exp_in == EXP_ONES) begin
      exp_out = OEXP_ONES;
      man_out = man_in;
    end else begin
      exp_out = OUT_EXP_W'(int'(exp_in) + BIAS_ADJ);
      man_out = man_in;
    end
    dbl = {sgn, exp_out, man_out, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/bf16x_out_stage.sv
module bf16x_out_stage
  import bf16x_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take,
  input  logic    load,
  input  result_t din,
  input  logic    out_ready,
  output logic    out_valid,
  output logic    free,
  output result_t dout
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (free) begin
      out_valid <= take && load;
      if (take && load) dout <= din;
    end
  end
endmodule

// File: rtl/bf16_imm_expand.sv
module bf16_imm_expand
  import bf16x_pkg::*;
#(
  parameter logic [OPC_W-1:0] MAJOR_OP = DEF_MAJOR,
  parameter logic [XOP_W-1:0] EXT_OP   = DEF_EXT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DBL_W-1:0]  out_data,
  output logic [RD_W-1:0]   out_rd
);
  logic [IMM_W-1:0] imm;
  logic [RD_W-1:0]  rd;
  logic             hit;
  logic [DBL_W-1:0] dbl;
  result_t          nxt;
  result_t          held;

  bf16x_field_split #(.MAJOR_OP(MAJOR_OP), .EXT_OP(EXT_OP)) u_split (
    .insn (in_insn),
    .imm  (imm),
    .rd   (rd),
    .hit  (hit)
  );

  bf16x_widen u_widen (
    .imm (imm),
    .dbl (dbl)
  );

  assign nxt.dbl = dbl;
  assign nxt.rd  = rd;

  bf16x_out_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (in_valid),
    .load      (hit),
    .din       (nxt),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .free      (in_ready),
    .dout      (held)
  );

  assign out_data = held.dbl;
  assign out_rd   = held.rd;
endmodule

// File: rtl/bf16_imm_expand_chk.sv
module bf16_imm_expand_chk
  import bf16x_pkg::*;
#(
  parameter logic [OPC_W-1:0] MAJOR_OP = DEF_MAJOR,
  parameter logic [XOP_W-1:0] EXT_OP   = DEF_EXT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [INSN_W-1:0] in_insn,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DBL_W-1:0]  out_data,
  input logic [RD_W-1:0]   out_rd
);
  logic match;
  assign match = (in_insn[31:26] == MAJOR_OP) && (in_insn[5:1] == EXT_OP);

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_rd)) // R8
    else $error("stalled result changed");

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready) // R8
    else $error("input open during stall");

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && match |=> out_valid) // R7
    else $error("result missing after accept");

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && !(in_valid && match) |=> !out_valid) // R2
    else $error("output without matching word");

  AST_LOW_FRAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[44:0] == '0) // R4
    else $error("low fraction bits set");

  AST_NO_DBL_SUBNORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data[62:52] == '0 |-> out_data[51:0] == '0) // R6
    else $error("double subnormal produced");
endmodule

bind bf16_imm_expand bf16_imm_expand_chk #(.MAJOR_OP(MAJOR_OP), .EXT_OP(EXT_OP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_insn   (in_insn),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_rd    (out_rd)
);

// File: tb/sim_bf16_imm_expand.sv
`timescale 1ns/1ps
module sim_bf16_imm_expand;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic [4:0]  out_rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [68:0] expq [$];
  string       tagq [$];

  always #5 clk = ~clk;

  bf16_imm_expand u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_rd(out_rd)
  );

  function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] rd,
                                     input logic [15:0] imm, input logic [4:0] xo);
    return {maj, rd, imm[14:0], xo, imm[15]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [68:0] act,
                       input logic [68:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one word; queue its expected result when it matches.
  task automatic send(input logic [31:0] w, input bit hit, input logic [63:0] dbl,
                      input string tag);
    in_valid = 1'b1;
    in_insn  = w;
    while (!in_ready) begin
      @(posedge clk); #1;
    end
    if (hit) begin
      expq.push_back({dbl, w[25:21]});
      tagq.push_back(tag);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic vec(input logic [4:0] rd, input logic [15:0] imm,
                     input logic [63:0] dbl, input string tag);
    send(mk(6'd19, rd, imm, 5'd3), 1'b1, dbl, tag);
  endtask

  // Monitor: scoreboard compare at each transfer
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2 unexpected output", {out_data, out_rd}, '0);
      end else begin
        logic [68:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({out_data, out_rd} === e, t, {out_data, out_rd}, e);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      check(1'b0, "watchdog", '0, '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R9 out_valid after reset", {68'b0, out_valid}, '0);
    check(in_ready == 1'b1, "R9 in_ready after reset", {68'b0, in_ready}, 69'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    vec(5'd4,  16'h0000, 64'h0000000000000000, "R3 +0");
    vec(5'd5,  16'h8000, 64'h8000000000000000, "R3 -0");
    vec(5'd6,  16'h3F80, 64'h3FF0000000000000, "R4 +1.0");
    vec(5'd7,  16'hBF80, 64'hBFF0000000000000, "R4 -1.0");
    vec(5'd8,  16'hBFC0, 64'hBFF8000000000000, "R4 -1.5");
    vec(5'd9,  16'h3FFF, 64'h3FFFE00000000000, "R4 1.9921875");
    vec(5'd10, 16'h0080, 64'h3810000000000000, "R4 min normal");
    vec(5'd11, 16'h7F80, 64'h7FF0000000000000, "R5 +inf");
    vec(5'd12, 16'hFF80, 64'hFFF0000000000000, "R5 -inf");
    vec(5'd13, 16'h7FC0, 64'h7FF8000000000000, "R5 qNaN");
    vec(5'd14, 16'h7F81, 64'h7FF0200000000000, "R5 sNaN payload");
    vec(5'd15, 16'h0001, 64'h37A0000000000000, "R6 min subnormal");
    vec(5'd16, 16'h8005, 64'hB7C4000000000000, "R6 neg subnormal");
    vec(5'd31, 16'h0040, 64'h3800000000000000, "R6 max lz0 subnormal R1 rd31");

    // R7: one-cycle latency, single-cycle valid
    @(posedge clk); #1;
    vec(5'd1, 16'h4000, 64'h4000000000000000, "R7 +2.0");
    check(out_valid == 1'b1, "R7 valid after accept", {68'b0, out_valid}, 69'd1);
    @(posedge clk); #1;
    check(out_valid == 1'b0, "R7 valid one cycle", {68'b0, out_valid}, '0);

    // R2: non-matching major and extended opcodes
    send(mk(6'd18, 5'd2, 16'h3F80, 5'd3), 1'b0, '0, "R2");
    check(out_valid == 1'b0, "R2 wrong major", {68'b0, out_valid}, '0);
    send(mk(6'd19, 5'd2, 16'h3F80, 5'd4), 1'b0, '0, "R2");
    check(out_valid == 1'b0, "R2 wrong ext", {68'b0, out_valid}, '0);

    // R8: back-pressure
    out_ready = 1'b0;
    vec(5'd20, 16'hC040, 64'hC008000000000000, "R8 stalled -3.0");
    in_valid = 1'b1;
    in_insn  = mk(6'd19, 5'd21, 16'h4120, 5'd3);
    for (int i = 0; i < 3; i++) begin
      check(in_ready == 1'b0, "R8 in_ready low", {68'b0, in_ready}, '0);
      check(out_valid && out_data == 64'hC008000000000000 && out_rd == 5'd20,
            "R8 held result", {out_data, out_rd}, {64'hC008000000000000, 5'd20});
      @(posedge clk); #1;
    end
    expq.push_back({64'h4024000000000000, 5'd21});
    tagq.push_back("R8 after stall 10.0");
    out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check(expq.size() == 0, "R7 all results delivered", 69'(expq.size()), '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule